// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked front end for an external static RAM of 32,768 bytes that has no clock of its own. The host side is a request port. One `req` cycle in idle starts a single-byte read or write, and a one-cycle `ready` pulse marks its completion. On the memory side the block produces a 15-bit address, three active-low strobes (chip select, write strobe, output enable) and a data bus split into an outgoing value, an outgoing drive enable and an incoming value. The pad ring combines these three into one tri-state bus.

Every memory timing minimum is a parameter in picoseconds, and the clock period is a parameter too. The block turns each minimum into a whole number of clock cycles for each phase: address setup, write strobe, write data hold, and read access. A write raises its strobe while chip select stays low, then keeps driving the data for a hold phase before it lets go of the bus. The bus is driven only while the memory's output enable is high and has been high for at least one earlier cycle. The address moves only on an edge where chip select was high just before. Between accesses all three strobes sit high, so the memory is in standby.

Top module: `sram_ctrl`

## Requirements
- R1: During and right after a synchronous active-high reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `ready` is 0 and `rdata` is 0.
- R2: In every cycle with no access in progress, including the `ready` cycle, the three strobes are 1 and `mem_dq_oe` is 0.
- R3: The write sequence runs as follows. A write is accepted on the edge where `req`=1 and `wr`=1 in idle. Setup phase: `mem_ce_n`=0, `mem_we_n`=1, `mem_oe_n`=1, bus not driven. Strobe phase: `mem_we_n`=0 and the bus drives the accepted `wdata`. Hold phase: `mem_we_n`=1, `mem_ce_n`=0, bus still driven. Then the block returns to idle.
- R4: `mem_oe_n` is 1 throughout a write, and `mem_we_n` is low only while `mem_ce_n` is low.
- R5: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and it can rise only when `mem_oe_n` was also 1 in the previous cycle.
- R6: `mem_addr` changes only on an edge where `mem_ce_n` was 1 before that edge.
- R7: A read is accepted with `req`=1 and `wr`=0 in idle. It holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and drives no data for the access phase. `mem_dq_i` is captured into `rdata` on the edge that ends the phase, which is the same edge that raises `mem_oe_n`.
- R8: `ready` is 1 for exactly one cycle, the first idle cycle after an access. `rdata` then holds the last read value, and a write leaves it unchanged.
- R9: `req` is sampled only in idle. A request raised during an access starts no access, either during that access or after it ends.
- R10: `addr`, `wr` and `wdata` are read only on the accepting edge. Changing them later does not alter `mem_addr` or `mem_dq_o` for the rest of that access.
- R11: Each phase length is the ceiling of its minimum time divided by the clock period, and never less than 1. The strobe phase also covers the data setup time and the rest of the address-to-write-end time. The hold phase also pads the write out to the cycle-time minimum. The access phase covers address access, output-enable access and read cycle time. At the default parameters the phases are 1, 1, 1 and 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled in idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Word address |
| wdata | input | 8 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read data |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Data returned from memory |

## Verification
Every pin output is registered, so the first phase of an access shows on the pins in the cycle after the accepting edge. The bench computes the phase lengths from the timing minimums and the clock period on its own, then walks one negative clock edge at a time: setup, strobe and hold for a write, or the access phase for a read. `ready` and the captured `rdata` are due exactly one cycle after the last phase cycle. The bench samples each of these at that point, and it checks again one cycle later that a request made while busy left the block idle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ASETUP = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_ACCESS = 3'd4
  } phase_e;

  // Whole clock cycles covering a time in picoseconds, never below one.
  function automatic int ps_to_cycles(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R11
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int N_AS = 1,
  parameter int N_WP = 1,
  parameter int N_DH = 1,
  parameter int N_AA = 2,
  parameter int CW   = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   wr,
  output phase_e state,
  output phase_e nxt
);

  localparam logic [CW-1:0] LD_AS = CW'(N_AS - 1);
  localparam logic [CW-1:0] LD_WP = CW'(N_WP - 1);
  localparam logic [CW-1:0] LD_DH = CW'(N_DH - 1);
  localparam logic [CW-1:0] LD_AA = CW'(N_AA - 1);

  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    case (state)
      PH_IDLE: begin
        if (req) begin
          load = 1'b1;
          if (wr) begin
            nxt      = PH_ASETUP;
            load_val = LD_AS;
          end else begin
            nxt      = PH_ACCESS;
            load_val = LD_AA;
          end
        end
      end
      PH_ASETUP: begin
        if (expired) begin
          nxt      = PH_STROBE;
          load     = 1'b1;
          load_val = LD_WP;
        end
      end
      PH_STROBE: begin
        if (expired) begin
          nxt      = PH_HOLD;
          load     = 1'b1;
          load_val = LD_DH;
        end
      end
      PH_HOLD: begin
        if (expired) nxt = PH_IDLE;
      end
      PH_ACCESS: begin
        if (expired) nxt = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PH_IDLE;
    else     state <= nxt;
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  // R3
  strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_STROBE) |-> ($past(state) inside {PH_ASETUP, PH_STROBE}));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == PH_HOLD && state == PH_IDLE) |=> (state != PH_ASETUP || $past(req)));

endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        state,
  input  phase_e        nxt,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  output logic          ready,
  output logic [DW-1:0] rdata
);

  logic accept;
  logic finish;
  logic capture;

  assign accept  = (state == PH_IDLE) && (nxt != PH_IDLE);
  assign finish  = (state != PH_IDLE) && (nxt == PH_IDLE);
  assign capture = (state == PH_ACCESS) && (nxt == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      ready     <= 1'b0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr;
        mem_dq_o <= wdata;
      end
      mem_ce_n  <= (nxt == PH_IDLE);
      mem_we_n  <= (nxt != PH_STROBE);
      mem_oe_n  <= (nxt != PH_ACCESS);
      mem_dq_oe <= (nxt == PH_STROBE) || (nxt == PH_HOLD);
      ready     <= finish;
      if (capture) rdata <= mem_dq_i;
    end
  end

  // R5
  bus_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && mem_oe_n));

  // R5
  bus_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R4
  strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R6
  addr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> $past(mem_ce_n));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R7
  read_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_oe_n) && !$past(rst)) |-> $stable(rdata));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int CLK_PS   = 8000,
  parameter int T_AS_PS  = 0,
  parameter int T_WP_PS  = 7000,
  parameter int T_AW_PS  = 8000,
  parameter int T_DW_PS  = 5000,
  parameter int T_DH_PS  = 0,
  parameter int T_WC_PS  = 10000,
  parameter int T_AA_PS  = 10000,
  parameter int T_OE_PS  = 3000,
  parameter int T_RC_PS  = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int N_AS  = ps_to_cycles(T_AS_PS, CLK_PS);
  localparam int N_WP  = ps_to_cycles(max3(T_WP_PS, T_DW_PS, T_AW_PS - N_AS * CLK_PS), CLK_PS);
  localparam int N_DH  = max2(ps_to_cycles(T_DH_PS, CLK_PS),
                              ps_to_cycles(T_WC_PS, CLK_PS) - N_AS - N_WP);
  localparam int N_AA  = ps_to_cycles(max3(T_AA_PS, T_OE_PS, T_RC_PS), CLK_PS);
  localparam int N_MAX = max2(max3(N_AS, N_WP, N_DH), N_AA);
  localparam int CW    = max2($clog2(N_MAX + 1), 1);

  phase_e state;
  phase_e nxt;

  sram_ctrl_fsm #(
    .N_AS (N_AS),
    .N_WP (N_WP),
    .N_DH (N_DH),
    .N_AA (N_AA),
    .CW   (CW)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .wr    (wr),
    .state (state),
    .nxt   (nxt)
  );

  sram_pin_drive #(
    .AW (AW),
    .DW (DW)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .nxt       (nxt),
    .addr      (addr),
    .wdata     (wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .ready     (ready),
    .rdata     (rdata)
  );

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

  localparam int CLK_PS = 8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int e_as, e_wp, e_dh, e_aa;
  logic [7:0] last_rd = 8'h00;

  logic [7:0] model [int];
  logic [7:0] score [int];

  always #4 clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  function automatic logic [7:0] fill(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Memory model: write on the rising write strobe, combinational read.
  always @(posedge mem_we_n) begin
    if (!rst && !mem_ce_n && mem_dq_oe) model[int'(mem_addr)] = mem_dq_o;
  end

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_i = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : fill(mem_addr);
    else
      mem_dq_i = 8'h00;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe};
    chk(act == exp, tag, int'(act), int'(exp));
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    // busy request with junk fields: must be ignored (R9, R10)
    req = 1'b1; wr = 1'b0; addr = ~a; wdata = ~d;
    for (int i = 0; i < e_as; i++) begin
      chk_pins("R3 R11 setup pins", 4'b0110);
      chk(mem_addr == a, "R10 setup addr", int'(mem_addr), int'(a));
      req = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < e_wp; i++) begin
      chk_pins("R3 R4 R11 strobe pins", 4'b0011);
      chk(mem_dq_o == d, "R10 strobe data", int'(mem_dq_o), int'(d));
      @(negedge clk);
    end
    for (int i = 0; i < e_dh; i++) begin
      chk_pins("R3 R11 hold pins", 4'b0111);
      @(negedge clk);
    end
    chk(ready == 1'b1, "R8 write ready", int'(ready), 1);
    chk_pins("R2 idle after write", 4'b1110);
    chk(rdata == last_rd, "R8 rdata kept on write", int'(rdata), int'(last_rd));
    @(negedge clk);
    chk(ready == 1'b0, "R8 single pulse", int'(ready), 0);
    chk(mem_ce_n == 1'b1, "R9 no access from busy req", int'(mem_ce_n), 1);
    score[int'(a)] = d;
  endtask

  task automatic do_read(input logic [14:0] a);
    logic [7:0] e;
    e = score.exists(int'(a)) ? score[int'(a)] : fill(a);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a; wdata = $urandom;
    @(negedge clk);
    req = 1'b0; addr = $urandom;
    for (int i = 0; i < e_aa; i++) begin
      chk_pins("R7 R11 access pins", 4'b0100);
      chk(mem_addr == a, "R7 access addr", int'(mem_addr), int'(a));
      @(negedge clk);
    end
    chk(ready == 1'b1, "R8 read ready", int'(ready), 1);
    chk(rdata == e, "R7 read data", int'(rdata), int'(e));
    chk_pins("R2 idle after read", 4'b1110);
    last_rd = e;
    @(negedge clk);
    chk(ready == 1'b0, "R8 single pulse", int'(ready), 0);
  endtask

  initial begin
    e_as = cyc(0);
    e_wp = cyc(mx(mx(7000, 5000), 8000 - e_as * CLK_PS));
    e_dh = mx(cyc(0), cyc(10000) - e_as - e_wp);
    e_aa = cyc(mx(10000, 3000));
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    chk_pins("R1 reset pins", 4'b1110);
    chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_pins("R1 after reset", 4'b1110);
    chk(rdata == 8'h00, "R1 reset rdata", int'(rdata), 0);
    repeat (2) @(negedge clk);
    chk_pins("R2 standby", 4'b1110);

    do_write(15'h0000, 8'h00);
    do_write(15'h7FFF, 8'hFF);
    do_read(15'h0000);
    do_read(15'h7FFF);
    do_read(15'h1234);
    do_write(15'h1234, 8'hA5);
    do_read(15'h1234);
    do_read(15'h1234);
    do_write(15'h1234, 8'h5A);
    do_read(15'h1234);

    for (int k = 0; k < 80; k++) begin
      logic [14:0] a;
      a = ($urandom_range(3) == 0) ? 15'($urandom) : 15'($urandom_range(63));
      if ($urandom_range(1) == 1) do_write(a, 8'($urandom));
      else                        do_read(a);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule